// File: doc/BRIEF.md
# Serial ADC Frame and Power-State Controller

This block is the digital control for a 10-bit successive-approximation converter with a three-wire serial port. The host drives a convert-start line and the serial clock, and reads one data line. A falling edge on convert-start begins a frame. The block captures the parallel sample and the two sub-bits at that point and drives the data line low. It then shifts out a fixed 16-bit frame, one bit per serial-clock rising edge.

The host selects the next power state by choosing when convert-start rises, measured in clock edges since the frame began:

- **Late rise:** the output stays driven, so the next frame can follow directly.
- **Mid-frame rise:** the converter naps (partial power-down). A second mid-frame rise while napping switches it off (full power-down).
- **No rise:** if convert-start stays low to the end of the frame, the output is released to high impedance.

Leaving either power-down state takes a wake frame in which convert-start is held low long enough. The first frame after reset is a calibration frame, and its result is flagged as not valid.

The serial clock is the block clock. Convert-start is synchronised into that domain and edge-detected there. Every edge count below is therefore the count the block holds when it sees the synchronised edge. A change on the pin becomes visible on the third rising clock edge after it.

Top module: `adc_serial_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with convert-start high, the outputs are in this state: output enable 0, data 0, power state 0 (normal), track 1, result-valid 0.
- R2: A synchronised falling edge of convert-start starts a frame on the same clock edge. The sample and sub-bits are captured at that edge, and later changes on those inputs do not alter the frame. From that edge the output enable is 1 and the data output is 0.
- R3: After the k-th rising edge of a normal frame, the data output carries a fixed pattern:
  - k = 1 to 3: 0
  - k = 4 to 13: sample bit 13-k (MSB first)
  - k = 14: sub-bit 1
  - k = 15: sub-bit 0
  - k = 16: 0
- R4: If convert-start is still low when the count is 16, the output enable drops to 0 on the next rising edge. Whenever the output enable is 0, the data output is 0.
- R5: A rise seen at count 14 or 15 keeps the output enable at 1 through the end of the frame and until the next frame starts.
- R6: In the normal state, a rise seen at count 4 to 13 sets the power state to 1 (partial) and drops the output enable on that edge.
- R7: In the partial state, a wake frame with a rise seen at count 4 to 13 sets the power state to 2 (full).
- R8: A frame started in either power-down state is a wake frame, and its data output stays 0 throughout. The power state returns to 0 when a rise is seen at count 14 or more, or when the count reaches 16 with convert-start still low. A rise seen at count 4 to 13 in the full state leaves the state at 2.
- R9: A rise seen at count 0 to 3 ends the frame, drops the output enable, and leaves the power state unchanged.
- R10: Track is 1 when no frame is running. It is 0 from the frame start until the count reaches 14, and 1 from then on.
- R11: result-valid is 0 during the first frame after reset. It is 1 during every later normal frame, including the first normal frame after a wake.
- R12: The power state takes only the values 0, 1 and 2, and never steps from 0 straight to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock, used as the block clock |
| rst_ni | input | 1 | Active-low reset |
| cnvst_i | input | 1 | Convert-start, asynchronous, idles high |
| sample_i | input | DATA_W (10) | Parallel conversion result |
| sub_i | input | SUB_W (2) | Sub-bits S1 (bit 1) and S0 (bit 0) |
| dout_o | output | 1 | Serial data output |
| dout_oe_o | output | 1 | Output enable, models the tri-state driver |
| pwr_state_o | output | 2 | Power state: 0 normal, 1 partial, 2 full |
| track_o | output | 1 | Sampling stage is tracking |
| result_valid_o | output | 1 | Current frame result is valid (not calibration) |

## Verification
Some properties are checked by assertions on every cycle:
- A synchronised fall always turns the driver on with the count cleared.
- The power state never leaves its three legal codes, and never jumps from normal straight to off.
- Any return to normal is preceded by a count of at least 14.
- The released line is never high, and the leading zeros are present.

The exact bit order of the frame, the captured sample, and the continuous-mode hand-over from one frame to the next can only be shown by the bench's scenarios. The same holds for the calibration flag and the full power-down and wake sequences.

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;

    typedef enum logic [1:0] {
        PWR_RUN = 2'd0,
        PWR_NAP = 2'd1,
        PWR_OFF = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/adc_serial_sync.sv
module adc_serial_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic fall_o,
    output logic rise_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    logic              last_w;

    assign last_w = sh_q[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '1;
                else         sh_q <= {sh_q[STAGES-2:0], async_i};
            end
        end else begin : g_single
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '1;
                else         sh_q <= async_i;
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b1;
        else         prev_q <= last_w;
    end

    assign fall_o = prev_q & ~last_w;
    assign rise_o = ~prev_q & last_w;

endmodule

// File: rtl/adc_serial_bitsel.sv
module adc_serial_bitsel #(
    parameter int LEAD   = 3,
    parameter int DATA_W = 10,
    parameter int SUB_W  = 2,
    parameter int CNT_W  = 5
) (
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [DATA_W+SUB_W-1:0] payload_i,
    output logic                    bit_o
);
    localparam int P     = DATA_W + SUB_W;
    localparam int IDX_W = $clog2(P);

    int               kpos;
    logic [IDX_W-1:0] idx;

    always_comb begin
        kpos  = int'(cnt_i);
        idx   = '0;
        bit_o = 1'b0;
        if (kpos > LEAD && kpos <= LEAD + P) begin
            idx   = IDX_W'(LEAD + P - kpos);
            bit_o = payload_i[idx];
        end
    end

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
    import adc_serial_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int SUB_W       = 2,
    parameter int LEAD        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cnvst_i,
    input  logic [DATA_W-1:0] sample_i,
    input  logic [SUB_W-1:0]  sub_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic [1:0]        pwr_state_o,
    output logic              track_o,
    output logic              result_valid_o
);
    localparam int P         = DATA_W + SUB_W;
    localparam int FRAME_LEN = LEAD + P + 1;
    localparam int CONT_LO   = FRAME_LEN - 2;
    localparam int PD_LO     = LEAD + 1;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             wake;
        logic             oe;
        logic             cont;
        pwr_state_e       pwr;
        logic             cal_pend;
        logic             valid;
        logic [P-1:0]     payload;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  fall_w, rise_w, bit_w;

    adc_serial_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(cnvst_i),
        .fall_o (fall_w),
        .rise_o (rise_w)
    );

    adc_serial_bitsel #(
        .LEAD  (LEAD),
        .DATA_W(DATA_W),
        .SUB_W (SUB_W),
        .CNT_W (CNT_W)
    ) bitsel_i (
        .cnt_i    (st_q.cnt),
        .payload_i(st_q.payload),
        .bit_o    (bit_w)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy && st_q.cnt != CNT_W'(FRAME_LEN))
            st_d.cnt = st_q.cnt + 1'b1;

        if (fall_w) begin
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
            st_d.oe   = 1'b1;
            st_d.cont = 1'b0;
            if (st_q.pwr == PWR_RUN) begin
                st_d.wake     = 1'b0;
                st_d.payload  = {sample_i, sub_i};
                st_d.valid    = ~st_q.cal_pend;
                st_d.cal_pend = 1'b0;
            end else begin
                st_d.wake  = 1'b1;
                st_d.valid = 1'b0;
            end
        end else if (st_q.busy && rise_w) begin
            if (st_q.cnt >= CNT_W'(CONT_LO)) begin
                if (st_q.wake || st_q.cnt == CNT_W'(FRAME_LEN)) begin
                    st_d.busy = 1'b0;
                    st_d.oe   = 1'b0;
                    if (st_q.wake) st_d.pwr = PWR_RUN;
                end else begin
                    st_d.cont = 1'b1;
                end
            end else if (st_q.cnt >= CNT_W'(PD_LO)) begin
                st_d.busy = 1'b0;
                st_d.oe   = 1'b0;
                st_d.pwr  = (st_q.pwr == PWR_RUN) ? PWR_NAP : PWR_OFF;
            end else begin
                st_d.busy = 1'b0;
                st_d.oe   = 1'b0;
            end
        end else if (st_q.busy && st_q.cnt == CNT_W'(FRAME_LEN)) begin
            st_d.busy = 1'b0;
            st_d.oe   = st_q.cont;
            if (st_q.wake) st_d.pwr = PWR_RUN;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q          <= '0;
            st_q.pwr      <= PWR_RUN;
            st_q.cal_pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o         = st_q.busy & ~st_q.wake & bit_w;
    assign dout_oe_o      = st_q.oe;
    assign pwr_state_o    = st_q.pwr;
    assign track_o        = ~st_q.busy | (st_q.cnt >= CNT_W'(CONT_LO));
    assign result_valid_o = st_q.valid;

    a_r2_start_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_w |=> (dout_oe_o && st_q.cnt == '0 && !dout_o));

    a_r12_pwr_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_state_o != 2'd3);

    a_r12_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 2'd0) |=> (pwr_state_o != 2'd2));

    a_r8_wake_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o != 2'd0) |=> (pwr_state_o != 2'd0 || $past(st_q.cnt) >= CNT_W'(CONT_LO)));

    a_r6_nap_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_state_o == 2'd0) |=> (pwr_state_o != 2'd1 || !dout_oe_o));

    a_r4_hiz_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dout_oe_o |-> !dout_o);

    a_r3_lead_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && st_q.cnt <= CNT_W'(LEAD)) |-> !dout_o);

endmodule

// File: tb/adc_serial_ctrl_tb.sv
`timescale 1ns/1ps
module adc_serial_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnvst = 1'b1;
    logic [9:0] sample = '0;
    logic [1:0] sub = '0;
    logic       dout, oe, track, valid;
    logic [1:0] pwr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_serial_ctrl dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cnvst_i       (cnvst),
        .sample_i      (sample),
        .sub_i         (sub),
        .dout_o        (dout),
        .dout_oe_o     (oe),
        .pwr_state_o   (pwr),
        .track_o       (track),
        .result_valid_o(valid)
    );

    // {sample, sub} pairs for single frames
    localparam logic [11:0] VEC [6] = '{
        12'b1010101010_01, 12'b0000000001_10, 12'b1000000000_11,
        12'b1111111111_00, 12'b0110011001_10, 12'b0000000000_01
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // frame word in output order: 3 zeros, data MSB first, S1, S0, one zero
    function automatic logic [15:0] frame_word(logic [9:0] d, logic [1:0] s);
        return {3'b000, d, s, 1'b0};
    endfunction

    task automatic start_frame();
        cnvst = 1'b0;
        tick(3);
    endtask

    // start a frame, raise convert-start after m edges; seen at count m+2
    task automatic frame_rise(int m);
        start_frame();
        tick(m);
        cnvst = 1'b1;
        tick(3);
    endtask

    task automatic single_frame(logic [11:0] v, logic exp_valid);
        logic [15:0] w;
        w      = frame_word(v[11:2], v[1:0]);
        sample = v[11:2];
        sub    = v[1:0];
        start_frame();
        check("R2 oe at start", oe, 1);
        check("R2 dout at start", dout, 0);
        check("R10 track low at start", track, 0);
        check("R11 valid flag", valid, exp_valid);
        sample = ~v[11:2];
        sub    = ~v[1:0];
        for (int k = 1; k <= 16; k++) begin
            tick(1);
            check("R3 frame bit", dout, w[16-k]);
            if (k == 13) check("R10 track before 14", track, 0);
            if (k == 14) check("R10 track at 14", track, 1);
        end
        tick(1);
        check("R4 release after 16", oe, 0);
        check("R4 dout low released", dout, 0);
        cnvst = 1'b1;
        tick(3);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] wa, wb;
        tick(3);
        check("R1 oe in reset", oe, 0);
        check("R1 pwr in reset", pwr, 0);
        rst_n = 1'b1;
        tick(3);
        check("R1 oe", oe, 0);
        check("R1 dout", dout, 0);
        check("R1 pwr", pwr, 0);
        check("R1 track", track, 1);
        check("R1 valid", valid, 0);

        // table of single frames, first one is the calibration frame (R11)
        for (int i = 0; i < 6; i++)
            single_frame(VEC[i], (i != 0));

        // R5 continuous conversion
        wa = frame_word(10'h2C5, 2'b10);
        wb = frame_word(10'h1B3, 2'b01);
        sample = 10'h2C5; sub = 2'b10;
        start_frame();
        for (int k = 1; k <= 16; k++) begin
            tick(1);
            if (k == 12) cnvst = 1'b1;
            if (k == 14) begin
                cnvst = 1'b0;
                sample = 10'h1B3; sub = 2'b01;
            end
            check("R5 first frame bit", dout, wa[16-k]);
            check("R5 oe held", oe, 1);
        end
        tick(1);
        check("R5 oe at next start", oe, 1);
        check("R5 next frame dout", dout, 0);
        for (int k = 1; k <= 16; k++) begin
            tick(1);
            check("R5 second frame bit", dout, wb[16-k]);
        end
        tick(1);
        check("R4 release after second frame", oe, 0);
        cnvst = 1'b1;
        tick(3);

        // R9 early rise aborts
        frame_rise(0);
        check("R9 abort oe", oe, 0);
        check("R9 abort pwr", pwr, 0);

        // R6 partial power-down
        frame_rise(5);
        check("R6 pwr partial", pwr, 1);
        check("R6 oe released", oe, 0);
        tick(4);
        check("R6 stays partial", pwr, 1);

        // R9 early rise while partial
        frame_rise(0);
        check("R9 partial kept", pwr, 1);

        // R7 second sequence -> full; R8 wake frame carries zeros
        sample = 10'h3FF; sub = 2'b11;
        start_frame();
        check("R8 wake oe", oe, 1);
        for (int k = 1; k <= 5; k++) begin
            tick(1);
            check("R8 wake dout zero", dout, 0);
        end
        cnvst = 1'b1;
        tick(3);
        check("R7 pwr full", pwr, 2);
        check("R12 legal code", pwr != 2'd3, 1);

        frame_rise(5);
        check("R8 full stays full", pwr, 2);

        frame_rise(12);
        check("R8 wake to normal", pwr, 0);
        check("R8 oe after wake", oe, 0);

        // wake by holding low to end of frame
        frame_rise(5);
        check("R6 partial again", pwr, 1);
        start_frame();
        tick(17);
        check("R8 held wake normal", pwr, 0);
        check("R8 held wake released", oe, 0);
        cnvst = 1'b1;
        tick(3);

        single_frame(12'b1100110011_10, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule